// File: doc/BRIEF.md
# Carry-Gated Bit-Slice ALU

This block is a purely combinational, word-wide arithmetic and logic unit. Every function it offers comes out of one row of identical full-adder bit-slices joined by a ripple carry chain. A small opcode decoder sets a few control levers on that row:

- whether operand A is complemented before it enters the slices,
- where the initial carry comes from,
- whether carries may pass between slices at all,
- which slice output is taken as the result bit.

Addition uses the row as it is. Subtraction (B minus A) complements A and forces a carry of one into the lowest slice. Exclusive-OR is the sum output with every carry suppressed. AND is each slice's carry-generate term. Complementing A is the suppressed-carry sum with B held at zero. There is no separate logic unit.

A surrounding datapath drives the two operands, a carry input and a 3-bit opcode. It reads back the result word and a carry-out in the same cycle. The design holds no state.

Top module: `bitslice_alu`

## Requirements
- R1: With op_sel = 3'b000 (add), {carry_out, result} equals opnd_a + opnd_b + carry_in taken as a WIDTH+1 bit sum.
- R2: With op_sel = 3'b001 (subtract), result equals (opnd_b - opnd_a) modulo 2^WIDTH. carry_out is 1 exactly when opnd_b >= opnd_a (no borrow). carry_in has no effect.
- R3: With op_sel = 3'b010 (exclusive-OR), result equals opnd_a ^ opnd_b and carry_out is 0, whatever carry_in is.
- R4: With op_sel = 3'b011 (AND), result equals opnd_a & opnd_b and carry_out is 0, whatever carry_in is.
- R5: With op_sel = 3'b100 (complement), result equals ~opnd_a and carry_out is 0. Neither opnd_b nor carry_in has any effect.
- R6: With op_sel equal to 3'b101, 3'b110 or 3'b111, result is all zeros and carry_out is 0.
- R7: A carry travels through every slice. In add mode, opnd_a all ones, opnd_b zero and carry_in 1 give result 0 with carry_out 1. In subtract mode, equal operands give result 0 with carry_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand; complemented internally for subtract and complement |
| opnd_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into the lowest slice, used only by add |
| op_sel | input | 3 | Operation select (encoding in R1 to R6) |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry from the top slice for add and subtract, else 0 |

## Verification
The checker tests every opcode's arithmetic or logic identity against the ports each time the inputs change. These checks cover the add and subtract sums with their carry and no-borrow meaning, the bitwise results, the zero output for unused codes, and a carry-out of zero for the non-arithmetic operations. Some properties only the bench scenarios can show. One is that carry_in and opnd_b truly have no influence: the bench varies them while holding the rest steady and compares the two outputs. The other is the full-length carry ripple at the all-ones and equal-operand boundaries.

// File: rtl/bitslice_alu_pkg.sv
package bitslice_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_XOR  = 3'b010,
        OP_AND  = 3'b011,
        OP_NOTA = 3'b100
    } alu_op_e;

    // Control levers applied to the slice row
    typedef struct packed {
        logic inv_a;      // complement operand A before the slices
        logic zero_b;     // hold operand B at zero
        logic cin_one;    // force a one into the lowest carry
        logic cin_ext;    // pass the external carry into the lowest slice
        logic kill;       // suppress every carry between slices
        logic pick_gen;   // take the generate term instead of the sum
        logic pick_none;  // drive the result to zero
        logic carry_vis;  // expose the top carry at the port
    } slice_ctl_t;

    localparam slice_ctl_t CTL_ZERO = '{default: 1'b0};

    function automatic slice_ctl_t decode_op(input logic [2:0] code);
        slice_ctl_t c;
        c = CTL_ZERO;
        unique case (code)
            OP_ADD: begin
                c.cin_ext   = 1'b1;
                c.carry_vis = 1'b1;
            end
            OP_SUB: begin
                c.inv_a     = 1'b1;
                c.cin_one   = 1'b1;
                c.carry_vis = 1'b1;
            end
            OP_XOR: begin
                c.kill = 1'b1;
            end
            OP_AND: begin
                c.kill     = 1'b1;
                c.pick_gen = 1'b1;
            end
            OP_NOTA: begin
                c.inv_a  = 1'b1;
                c.zero_b = 1'b1;
                c.kill   = 1'b1;
            end
            default: begin
                c.kill      = 1'b1;
                c.pick_none = 1'b1;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bitslice_alu_decode.sv
module bitslice_alu_decode
    import bitslice_alu_pkg::*;
(
    input  logic [2:0] op_code,
    output slice_ctl_t ctl
);
    always_comb begin
        ctl = decode_op(op_code);
    end
endmodule

// File: rtl/bitslice_alu_slice.sv
// One full-adder bit built from six two-input gates; the last gate
// gates the outgoing carry so the chain can be silenced.
module bitslice_alu_slice (
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_in,
    input  logic kill,
    output logic sum_bit,
    output logic gen_bit,
    output logic c_out
);
    logic half_x;
    logic prop_c;
    logic raw_c;

    always_comb begin
        half_x  = a_bit ^ b_bit;
        sum_bit = half_x ^ c_in;
        gen_bit = a_bit & b_bit;
        prop_c  = half_x & c_in;
        raw_c   = gen_bit | prop_c;
        c_out   = raw_c & ~kill;
    end
endmodule

// File: rtl/bitslice_alu_chain.sv
module bitslice_alu_chain #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_vec,
    input  logic [WIDTH-1:0] b_vec,
    input  logic             c_first,
    input  logic             kill,
    output logic [WIDTH-1:0] sum_vec,
    output logic [WIDTH-1:0] gen_vec,
    output logic             c_last
);
    localparam int NCARRY = WIDTH + 1;

    logic [NCARRY-1:0] carry;

    assign carry[0] = c_first;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        bitslice_alu_slice u_slice (
            .a_bit   (a_vec[i]),
            .b_bit   (b_vec[i]),
            .c_in    (carry[i]),
            .kill    (kill),
            .sum_bit (sum_vec[i]),
            .gen_bit (gen_vec[i]),
            .c_out   (carry[i+1])
        );
    end

    assign c_last = carry[NCARRY-1];
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import bitslice_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    slice_ctl_t       ctl;
    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;
    logic             c_first;
    logic [WIDTH-1:0] sum_vec;
    logic [WIDTH-1:0] gen_vec;
    logic             c_last;

    bitslice_alu_decode u_dec (
        .op_code (op_sel),
        .ctl     (ctl)
    );

    always_comb begin
        a_eff   = ctl.inv_a  ? ~opnd_a : opnd_a;
        b_eff   = ctl.zero_b ? '0      : opnd_b;
        c_first = ctl.cin_one | (ctl.cin_ext & carry_in);
    end

    bitslice_alu_chain #(.WIDTH(WIDTH)) u_chain (
        .a_vec   (a_eff),
        .b_vec   (b_eff),
        .c_first (c_first),
        .kill    (ctl.kill),
        .sum_vec (sum_vec),
        .gen_vec (gen_vec),
        .c_last  (c_last)
    );

    always_comb begin
        if (ctl.pick_none)
            result = '0;
        else if (ctl.pick_gen)
            result = gen_vec;
        else
            result = sum_vec;
        carry_out = ctl.carry_vis & c_last;
    end
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             carry_in,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);
    localparam int WX = WIDTH + 1;

    logic [WX-1:0] add_ref;
    logic [WX-1:0] sub_ref;

    always_comb begin
        add_ref = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
        sub_ref = {1'b0, opnd_b} - {1'b0, opnd_a};
        if (!$isunknown({opnd_a, opnd_b, carry_in, op_sel, result, carry_out})) begin
            if (op_sel == 3'b000)
                AST_ADD_SUM: assert ({carry_out, result} == add_ref); // R1
            if (op_sel == 3'b001) begin
                AST_SUB_DIFF: assert (result == sub_ref[WIDTH-1:0]); // R2
                AST_SUB_NOBORROW: assert (carry_out == (opnd_b >= opnd_a)); // R2
            end
            if (op_sel == 3'b010)
                AST_XOR_BITS: assert (result == (opnd_a ^ opnd_b)); // R3
            if (op_sel == 3'b011)
                AST_AND_BITS: assert (result == (opnd_a & opnd_b)); // R4
            if (op_sel == 3'b100)
                AST_NOTA_BITS: assert (result == ~opnd_a); // R5
            if (op_sel > 3'b100)
                AST_UNUSED_ZERO: assert (result == '0 && !carry_out); // R6
            if (op_sel > 3'b001)
                AST_LOGIC_NO_CARRY: assert (!carry_out); // R3
        end
    end
endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/sim_bitslice_alu.sv
`timescale 1ns/1ps
module sim_bitslice_alu;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b, res;
    logic         ci, co;
    logic [2:0]   op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bitslice_alu #(.WIDTH(W)) u0 (
        .opnd_a(a), .opnd_b(b), .carry_in(ci), .op_sel(op),
        .result(res), .carry_out(co)
    );

    function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic c, input logic [2:0] o);
        case (o)
            3'b000: return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
            3'b001: return {(y >= x), y - x};
            3'b010: return {1'b0, x ^ y};
            3'b011: return {1'b0, x & y};
            3'b100: return {1'b0, ~x};
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b011: return "R4";
            3'b100: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string rq, input logic [W:0] exp);
        checks++;
        if ({co, res} !== exp) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h ci=%b: got co=%b res=%h, expected co=%b res=%h",
                     rq, op, a, b, ci, co, res, exp[W], exp[W-1:0]);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input logic [2:0] o, input string rq);
        @(negedge clk);
        a = x; b = y; ci = c; op = o;
        #1;
        check(rq, model(x, y, c, o));
    endtask

    initial begin
        logic [W:0] first;
        a = '0; b = '0; ci = 1'b0; op = 3'b000;
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state with zero inputs: add of zeros
        #1; check("R1", '0);

        // R1 directed
        apply(16'h0001, 16'h0001, 1'b0, 3'b000, "R1");
        apply(16'h8000, 16'h8000, 1'b1, 3'b000, "R1");
        // R7 full ripple
        apply(16'hFFFF, 16'h0000, 1'b1, 3'b000, "R7");
        apply(16'h1234, 16'h1234, 1'b0, 3'b001, "R7");
        apply(16'h0000, 16'h0000, 1'b0, 3'b001, "R7");
        // R2 borrow cases, carry_in ignored
        apply(16'h0005, 16'h0003, 1'b0, 3'b001, "R2");
        apply(16'h0005, 16'h0003, 1'b1, 3'b001, "R2");
        apply(16'h0000, 16'hFFFF, 1'b1, 3'b001, "R2");
        apply(16'hFFFF, 16'h0000, 1'b0, 3'b001, "R2");
        // R3 / R4 carry_in ignored
        apply(16'hFFFF, 16'hFFFF, 1'b1, 3'b010, "R3");
        apply(16'hFFFF, 16'hFFFF, 1'b1, 3'b011, "R4");
        apply(16'hA5A5, 16'h0F0F, 1'b0, 3'b011, "R4");
        // R5: B and carry_in have no effect
        apply(16'h3C3C, 16'h0000, 1'b0, 3'b100, "R5");
        first = {co, res};
        apply(16'h3C3C, 16'hFFFF, 1'b1, 3'b100, "R5");
        checks++;
        if ({co, res} !== first) begin
            errors++;
            $display("FAIL R5 B/carry_in changed output: got %h expected %h", {co, res}, first);
        end
        // R6 unused codes
        for (int k = 5; k < 8; k++)
            apply(16'hFFFF, 16'hFFFF, 1'b1, k[2:0], "R6");

        // constrained random over every opcode
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] x, y;
            logic [2:0]   o;
            x = W'($urandom());
            y = W'($urandom());
            if (n % 8 == 0) x = '1;
            if (n % 11 == 0) y = x;
            o = 3'(n % 8);
            apply(x, y, 1'($urandom()), o, req_of(o));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule